// File: doc/BRIEF.md
# Ping-Pong Pixel Prefetch Buffer

This block feeds a display with a steady stream of pixels taken from a word-wide external memory. Each memory word holds two 8-bit pixels. A fetch engine in the memory clock domain requests fixed-length burst reads from an external memory controller and writes the returned words into a 128-word dual-port buffer. A scan engine in the pixel clock domain reads the other port of the buffer and emits one pixel per pixel clock. It sends the low byte of each word first and then the high byte.

After reset the fetch engine fills both 64-word halves of the buffer. Only then does the scan side begin to emit pixels. Each time the scan side finishes the last word of a half, it toggles a refill flag. The flag crosses into the memory domain through a two-flop synchronizer, and the fetch engine then fetches the next 64-word block of the frame into that half. Every burst starts on a 64-word boundary, so no burst ever runs across a 128-word memory row. The frame address wraps to word 0 after the last word of the frame.

Top module: `vid_prefetch_buffer`

## Requirements
- R1: While either reset is held, and after reset until 128 words have been delivered to the block, `pix_valid` is 0 and the colour outputs are 0.
- R2: After reset, the first two burst requests carry word addresses 0 and 64, and they fill the whole buffer.
- R3: Every burst request address is a multiple of 64. Each granted burst takes exactly 64 words, one per cycle in which `mem_valid` is high. Bursts therefore never cross a 128-word row.
- R4: The pixels of one word are emitted on consecutive pixel clocks. Bits [7:0] of the word come first and bits [15:8] second.
- R5: Words are emitted in ascending frame order, starting at word 0. After word FRAME_WORDS-1 the stream continues with word 0.
- R6: After the initial fill, each burst request follows the previous one at the next 64-word block, modulo FRAME_WORDS. One burst is requested for each 64 words the scan side consumes.
- R7: Once `mem_req` is raised, it stays high and `mem_addr` stays unchanged until a cycle in which `mem_grant` is high.
- R8: Once `pix_valid` is high, it stays high on every following pixel clock until reset.
- R9: The colour outputs split each pixel byte as red = bits [7:5], green = bits [4:2] and blue = bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory-side clock |
| mem_rst_n | input | 1 | Synchronous active-low reset, memory domain |
| mem_req | output | 1 | Burst read request, held until granted |
| mem_addr | output | ADDR_W | Word address of the first word of the burst |
| mem_grant | input | 1 | Controller accepts the pending request |
| mem_valid | input | 1 | A read word is present on mem_data |
| mem_data | input | 16 | Read word from memory |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Synchronous active-low reset, pixel domain |
| pix_valid | output | 1 | Pixel outputs carry a pixel |
| pix_red | output | 3 | Red component |
| pix_green | output | 3 | Green component |
| pix_blue | output | 2 | Blue component |

## Verification
The hardest situation to reach from the ports is the frame wrap. There, the fetch address, the scan word counter and the buffer index must all return to zero together while refills are still in flight. The bench shrinks the frame to a few buffer lengths and runs several frames, so that both counters cross the wrap repeatedly. The memory model inserts random grant delays, random latency and random idle gaps between data words. These stretch refills toward the point where the scan side would catch up with them. The first grant is delayed for a long time to show that no pixel leaves the block before the buffer is full.

// File: rtl/pfb_pkg.sv
// Shared types for the pixel prefetch buffer.
package pfb_pkg;

    // Fetch engine states
    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_DATA = 2'd2
    } fetch_state_t;

    // One pixel byte split into its colour fields
    typedef struct packed {
        logic [2:0] red;
        logic [2:0] green;
        logic [1:0] blue;
    } pixel_t;

endpackage

// File: rtl/pfb_sync.sv
// Multi-flop synchronizer for a level signal entering a clock domain.
// Assumes the input changes slowly compared with the destination clock.
module pfb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/pfb_ram.sv
// Simple dual-port buffer: one write port on the memory clock and one
// registered read port on the pixel clock. No reset on the contents.
module pfb_ram #(
    parameter int WORDS = 128,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [WORDS];

    // Write port, memory domain
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered read port, pixel domain
    always_ff @(posedge rclk) begin
        rdata <= store[raddr];
    end
endmodule

// File: rtl/pfb_fetch.sv
// Memory-side fetch engine. After reset it requests two bursts that fill
// the whole buffer, then one burst per refill toggle from the pixel side.
// Assumes FRAME_WORDS is a multiple of the buffer size and bursts are one
// half of the buffer, so each burst is aligned and stays inside one row.
module pfb_fetch
    import pfb_pkg::*;
#(
    parameter int FRAME_WORDS = 240000,
    parameter int BUF_WORDS   = 128,
    parameter int ADDR_W      = 23,
    localparam int FA_W       = $clog2(FRAME_WORDS),
    localparam int BUF_AW     = $clog2(BUF_WORDS),
    localparam int HALF_AW    = BUF_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_tgl,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_grant,
    input  logic              mem_valid,
    input  logic [15:0]       mem_data,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_idx,
    output logic [15:0]       wr_data,
    output logic              fill_done
);
    fetch_state_t    state;
    logic [FA_W-1:0] fa;
    logic [1:0]      pending;
    logic            tgl_s, tgl_d, tgl_edge, grant_take, last_beat;

    pfb_sync #(.STAGES(2)) u_tgl_sync (
        .clk (clk), .rst_n (rst_n), .d (refill_tgl), .q (tgl_s)
    );

    assign tgl_edge   = tgl_s ^ tgl_d;
    assign grant_take = (state == F_REQ) && mem_grant;
    assign last_beat  = (state == F_DATA) && mem_valid && (&fa[HALF_AW-1:0]);

    // Remember the previous synchronized toggle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    // Count bursts still owed; two are owed at reset for the initial fill
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 2'd2;
        else        pending <= pending + {1'b0, tgl_edge} - {1'b0, grant_take};
    end

    // Burst sequencing: idle, request, then collect one half of words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
        end else begin
            case (state)
                F_IDLE:  if (pending != 2'd0) state <= F_REQ;
                F_REQ:   if (mem_grant)       state <= F_DATA;
                F_DATA:  if (last_beat)       state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    // Frame word address: advance per word, wrap at the end of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa <= '0;
        end else if (state == F_DATA && mem_valid) begin
            if (fa == FA_W'(FRAME_WORDS - 1)) fa <= '0;
            else                              fa <= fa + 1'b1;
        end
    end

    // Buffer is primed once a burst into the upper half completes
    always_ff @(posedge clk) begin
        if (!rst_n)                      fill_done <= 1'b0;
        else if (last_beat && fa[HALF_AW]) fill_done <= 1'b1;
    end

    assign mem_req  = (state == F_REQ);
    assign mem_addr = ADDR_W'(fa);
    assign wr_en    = (state == F_DATA) && mem_valid;
    assign wr_idx   = fa[BUF_AW-1:0];
    assign wr_data  = mem_data;

    // R7: an ungranted request stays up with a steady address
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_grant) |=> (mem_req && $stable(mem_addr)));

    // R3: requests start on a half-buffer boundary
    p_burst_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[HALF_AW-1:0] == '0));

    // R6: never more than two refills outstanding
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pending != 2'd3);
endmodule

// File: rtl/pfb_scan.sv
// Pixel-side scan engine. Waits for the primed flag, then emits one pixel
// per clock, low byte of each word first. It reads one word ahead so the
// registered buffer output is ready when the next word starts. It toggles
// the refill flag whenever it finishes the last word of a buffer half.
module pfb_scan
    import pfb_pkg::*;
#(
    parameter int FRAME_WORDS = 240000,
    parameter int BUF_WORDS   = 128,
    localparam int FA_W       = $clog2(FRAME_WORDS),
    localparam int BUF_AW     = $clog2(BUF_WORDS),
    localparam int HALF_AW    = BUF_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_done,
    output logic [BUF_AW-1:0] rd_idx,
    input  logic [15:0]       rd_q,
    output logic              refill_tgl,
    output logic              pix_valid,
    output logic [2:0]        pix_red,
    output logic [2:0]        pix_green,
    output logic [1:0]        pix_blue
);
    logic            fill_s, run, hi_sel, half_end;
    logic [FA_W-1:0] wc, wc_next;
    pixel_t          px;

    pfb_sync #(.STAGES(2)) u_fill_sync (
        .clk (clk), .rst_n (rst_n), .d (fill_done), .q (fill_s)
    );

    assign wc_next  = (wc == FA_W'(FRAME_WORDS - 1)) ? '0 : wc + 1'b1;
    assign rd_idx   = hi_sel ? wc_next[BUF_AW-1:0] : wc[BUF_AW-1:0];
    assign half_end = run && hi_sel && (&wc[HALF_AW-1:0]);

    // Start streaming once the primed flag arrives; stay running
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= run | fill_s;
    end

    // Byte select and frame word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_sel <= 1'b0;
            wc     <= '0;
        end else if (run) begin
            hi_sel <= ~hi_sel;
            if (hi_sel) wc <= wc_next;
        end
    end

    // Flip the refill flag when a half has been fully consumed
    always_ff @(posedge clk) begin
        if (!rst_n)        refill_tgl <= 1'b0;
        else if (half_end) refill_tgl <= ~refill_tgl;
    end

    assign px        = hi_sel ? rd_q[15:8] : rd_q[7:0];
    assign pix_valid = run;
    assign pix_red   = run ? px.red   : 3'd0;
    assign pix_green = run ? px.green : 3'd0;
    assign pix_blue  = run ? px.blue  : 2'd0;

    // R8: streaming never pauses once it has begun
    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_valid);

    // R6: the refill flag moves only after the last byte of a half
    p_refill_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refill_tgl) |-> $past(half_end));

    // R4: bytes alternate low then high while running
    p_byte_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/vid_prefetch_buffer.sv
// Top level: fetch engine, dual-port buffer and scan engine.
// Assumes FRAME_WORDS is a multiple of BUF_WORDS and that the memory
// controller delivers a granted burst of BUF_WORDS/2 words.
module vid_prefetch_buffer #(
    parameter int FRAME_WORDS = 240000,
    parameter int BUF_WORDS   = 128,
    parameter int ADDR_W      = 23,
    localparam int BUF_AW     = $clog2(BUF_WORDS)
) (
    input  logic              mem_clk,
    input  logic              mem_rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_grant,
    input  logic              mem_valid,
    input  logic [15:0]       mem_data,
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    output logic              pix_valid,
    output logic [2:0]        pix_red,
    output logic [2:0]        pix_green,
    output logic [1:0]        pix_blue
);
    logic              wr_en, fill_done, refill_tgl;
    logic [BUF_AW-1:0] wr_idx, rd_idx;
    logic [15:0]       wr_data, rd_q;

    pfb_fetch #(
        .FRAME_WORDS (FRAME_WORDS), .BUF_WORDS (BUF_WORDS), .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk (mem_clk), .rst_n (mem_rst_n), .refill_tgl (refill_tgl),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_grant (mem_grant),
        .mem_valid (mem_valid), .mem_data (mem_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .fill_done (fill_done)
    );

    pfb_ram #(.WORDS (BUF_WORDS), .DW (16)) u_ram (
        .wclk (mem_clk), .we (wr_en), .waddr (wr_idx), .wdata (wr_data),
        .rclk (pix_clk), .raddr (rd_idx), .rdata (rd_q)
    );

    pfb_scan #(.FRAME_WORDS (FRAME_WORDS), .BUF_WORDS (BUF_WORDS)) u_scan (
        .clk (pix_clk), .rst_n (pix_rst_n), .fill_done (fill_done),
        .rd_idx (rd_idx), .rd_q (rd_q), .refill_tgl (refill_tgl),
        .pix_valid (pix_valid), .pix_red (pix_red),
        .pix_green (pix_green), .pix_blue (pix_blue)
    );
endmodule

// File: tb/vid_prefetch_buffer_test.sv
`timescale 1ns/1ps
module vid_prefetch_buffer_test;
    localparam int FRAME  = 512;
    localparam int BURST  = 64;
    localparam int TARGET = 3600;
    localparam int LIMIT  = 150000;

    logic        mclk = 1'b0, pclk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b0;
    logic        mem_req, mem_grant = 1'b0, mem_valid = 1'b0;
    logic [22:0] mem_addr;
    logic [15:0] mem_data = '0;
    logic        pix_valid;
    logic [2:0]  pix_red, pix_green;
    logic [1:0]  pix_blue;

    int checks = 0, fails = 0, delivered = 0, pix_done = 0, cyc = 0;

    always #2.5   mclk = ~mclk;
    always #3.125 pclk = ~pclk;

    vid_prefetch_buffer #(.FRAME_WORDS (FRAME), .BUF_WORDS (128), .ADDR_W (23)) uut (
        .mem_clk (mclk), .mem_rst_n (mrst_n), .mem_req (mem_req),
        .mem_addr (mem_addr), .mem_grant (mem_grant), .mem_valid (mem_valid),
        .mem_data (mem_data), .pix_clk (pclk), .pix_rst_n (prst_n),
        .pix_valid (pix_valid), .pix_red (pix_red), .pix_green (pix_green),
        .pix_blue (pix_blue)
    );

    // Content of memory word a
    function automatic logic [15:0] word_val(input int unsigned a);
        return 16'((a * 32'd40503) ^ (a >> 3) ^ 32'h5A5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory controller model with random grant delay, latency and gaps
    initial begin
        int unsigned exp_base, a, dly;
        int burst_no;
        bit held;
        void'($urandom(32'd2024));
        exp_base = 0;
        burst_no = 0;
        wait (mrst_n);
        forever begin
            @(negedge mclk);
            while (!mem_req) @(negedge mclk);
            a    = 32'(mem_addr);
            dly  = (burst_no == 0) ? 40 : $urandom_range(0, 3);
            held = 1'b1;
            for (int i = 0; i < int'(dly); i++) begin
                @(negedge mclk);
                if (!mem_req || 32'(mem_addr) != a) held = 1'b0;
                if (burst_no == 0 && pix_valid) chk(1'b0, "R1 early pixel", 1, 0);
            end
            chk(held, "R7 request held", 32'(mem_addr), a);
            if (burst_no < 2) chk(a == exp_base, "R2 initial fill address", a, exp_base);
            else              chk(a == exp_base, "R6 refill address", a, exp_base);
            chk(a % BURST == 0, "R3 alignment", a % BURST, 0);
            exp_base = (exp_base + BURST) % FRAME;
            burst_no++;
            mem_grant = 1'b1;
            @(negedge mclk);
            mem_grant = 1'b0;
            repeat ($urandom_range(1, 4)) @(negedge mclk);
            for (int i = 0; i < BURST; i++) begin
                if ($urandom_range(0, 7) == 0) begin
                    mem_valid = 1'b0;
                    @(negedge mclk);
                end
                mem_valid = 1'b1;
                mem_data  = word_val(a + i);
                @(negedge mclk);
                delivered++;
            end
            mem_valid = 1'b0;
            mem_data  = '0;
            // R3: the design must be idle after exactly 64 words
            chk(!mem_req || 32'(mem_addr) == (a + BURST) % FRAME,
                "R3 burst length", 32'(mem_addr), (a + BURST) % FRAME);
        end
    end

    // Pixel stream checker
    initial begin
        bit started = 1'b0, hi = 1'b0;
        int unsigned w = 0;
        logic [7:0] eb, ab;
        wait (prst_n);
        forever begin
            @(negedge pclk);
            if (!started && pix_valid) begin
                started = 1'b1;
                chk(delivered >= 128, "R1 enable after full buffer", delivered, 128);
            end
            if (!started) begin
                chk(pix_red == 0 && pix_green == 0 && pix_blue == 0,
                    "R1 idle colour", {pix_red, pix_green, pix_blue}, 0);
            end else begin
                chk(pix_valid, "R8 valid sticky", pix_valid, 1);
                eb = hi ? word_val(w)[15:8] : word_val(w)[7:0];
                ab = {pix_red, pix_green, pix_blue};
                if (pix_done == 0)       chk(ab == eb, "R4 first byte is low byte", ab, eb);
                else if (w == 0 && !hi)  chk(ab == eb, "R5 frame wrap", ab, eb);
                else                     chk(ab == eb, "R5 stream order", ab, eb);
                chk(pix_red == eb[7:5] && pix_green == eb[4:2] && pix_blue == eb[1:0],
                    "R9 colour fields", ab, eb);
                if (hi) w = (w + 1) % FRAME;
                hi = ~hi;
                pix_done++;
            end
        end
    end

    // Reset, run and summary
    initial begin
        repeat (4) @(negedge mclk);
        chk(!pix_valid && !mem_req, "R1 reset state", {pix_valid, mem_req}, 0);
        @(negedge pclk);
        prst_n = 1'b1;
        @(negedge mclk);
        mrst_n = 1'b1;
        while (pix_done < TARGET && cyc < LIMIT) begin
            @(posedge mclk);
            cyc++;
        end
        if (cyc >= LIMIT) chk(1'b0, "watchdog R5", pix_done, TARGET);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule